// File: doc/BRIEF.md
# DMA request boundary splitter

This block takes a single DMA transfer request (start byte address, byte count and direction) and cuts it into a stream of bus request packets. Each packet is sized so that it never runs past a 4 KB page edge. It also stays within an effective per-direction limit, which is the smaller of a bus-configured value and a fixed internal cap. Packets leave over a valid/ready handshake, carrying address, length, direction and a flag on the final one.

When the whole transfer fits in one packet under every rule, it goes out unchanged, even if its start or end is not cacheline aligned. When more than one packet is needed, every packet except the final one ends on a cacheline boundary. Each such packet is made as long as the limit and the page allow. A new request is taken only after the final packet of the previous one has been accepted. The configured limits are sampled when a request is accepted.

Top module: `req_splitter`

## Requirements
- R1: After reset, `pkt_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only when no request is being issued. It is 0 from the cycle after a nonzero-length request is accepted until the cycle after its last packet is accepted, and then returns to 1.
- R3: A request with `req_len` of 0 is consumed and produces no packet; `pkt_valid` stays 0 and `req_ready` stays 1.
- R4: For every packet, (`pkt_addr` mod 4096) + `pkt_len` is at most 4096.
- R5: The effective limit is min(`cfg_wr_max`, 256) for writes and min(`cfg_rd_max`, 512) for reads. Both configuration inputs are byte counts, a power of two from 128 to 4096, sampled at request acceptance. Every packet length is at most the effective limit of its request.
- R6: If the request length is at most the effective limit and does not cross a 4 KB boundary, exactly one packet with the request address and length is produced, with `pkt_last` = 1, whatever its alignment.
- R7: Otherwise each packet whose `pkt_last` is 0 ends at an address that is a multiple of 64 (the cacheline size). It is the largest such end allowed by the effective limit and the page edge. The remaining bytes form a final packet as soon as they fit under R6's rule from the current address.
- R8: Packets are contiguous. The first starts at `req_addr`, each next one starts at the previous address plus its length, the lengths sum to `req_len`, and `pkt_last` is 1 only on the final packet.
- R9: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_addr`, `pkt_len`, `pkt_last` and `pkt_is_wr` hold their values.
- R10: `pkt_is_wr` equals the `req_is_wr` of the accepted request (1 = write, 0 = read) for all of its packets.
- R11: The first packet is valid in the cycle after the request is accepted. After a non-final packet is accepted, the next one is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request can be taken |
| req_addr | input | ADDR_W | Request start byte address |
| req_len | input | LEN_W | Request byte count |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| cfg_wr_max | input | LEN_W | Bus-configured write payload limit in bytes |
| cfg_rd_max | input | LEN_W | Bus-configured read request limit in bytes |
| pkt_valid | output | 1 | Packet presented |
| pkt_ready | input | 1 | Packet taken by downstream |
| pkt_addr | output | ADDR_W | Packet start byte address |
| pkt_len | output | LEN_W | Packet byte count |
| pkt_last | output | 1 | Final packet of the request |
| pkt_is_wr | output | 1 | Packet direction |

## Verification
A corrupted remaining count or address register shows up at the ports in the very next presented packet. It appears as a wrong start address, a length that breaks the page or cacheline rule, or a last flag that comes too early or never comes. A stuck busy state shows within one cycle as `req_ready` disagreeing with the expected idle point. The bench therefore compares every packet, including every stalled cycle, against a sequence it computes itself. That exposes such faults at the first packet they touch.

// File: rtl/split_pkg.sv
package split_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/split_limit.sv
module split_limit #(
  parameter int LEN_W  = 13,
  parameter int WR_CAP = 256,
  parameter int RD_CAP = 512
) (
  input  split_pkg::dir_e   dir,
  input  logic [LEN_W-1:0]  cfg_wr,
  input  logic [LEN_W-1:0]  cfg_rd,
  output logic [LEN_W-1:0]  lim
);
  localparam logic [LEN_W-1:0] CAP_WR = LEN_W'(WR_CAP);
  localparam logic [LEN_W-1:0] CAP_RD = LEN_W'(RD_CAP);

  // effective limit: smaller of bus setting and internal cap for the direction
  always_comb begin
    if (dir == split_pkg::DIR_WR) lim = (cfg_wr < CAP_WR) ? cfg_wr : CAP_WR;
    else                          lim = (cfg_rd < CAP_RD) ? cfg_rd : CAP_RD;
  end
endmodule

// File: rtl/split_chunk.sv
module split_chunk #(
  parameter int LEN_W      = 13,
  parameter int PAGE_BYTES = 4096,
  parameter int CL_BYTES   = 64
) (
  input  logic [$clog2(PAGE_BYTES)-1:0] off_in,
  input  logic [LEN_W-1:0]              rem,
  input  logic [LEN_W-1:0]              lim,
  output logic [LEN_W-1:0]              len,
  output logic                          last
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CL_W   = $clog2(CL_BYTES);
  localparam int W      = LEN_W + 1;
  localparam logic [W-1:0] PAGE = W'(PAGE_BYTES);

  logic [W-1:0] off, page_left, lim_end, lim_al, cut;

  always_comb begin
    off       = W'(off_in);
    page_left = PAGE - off;
    lim_end   = off + W'(lim);
    lim_al    = {lim_end[W-1:CL_W], {CL_W{1'b0}}};
    cut       = (lim_al < PAGE) ? lim_al : PAGE;
    // whole remainder fits: send it as is, no alignment
    last      = (W'(rem) <= W'(lim)) && (W'(rem) <= page_left);
    len       = last ? rem : LEN_W'(cut - off);
  end
endmodule

// File: rtl/req_splitter.sv
module req_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 13,
  parameter int PAGE_BYTES = 4096,
  parameter int CL_BYTES   = 64,
  parameter int WR_CAP     = 256,
  parameter int RD_CAP     = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_is_wr,
  input  logic [LEN_W-1:0]  cfg_wr_max,
  input  logic [LEN_W-1:0]  cfg_rd_max,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              pkt_last,
  output logic              pkt_is_wr
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CL_W   = $clog2(CL_BYTES);

  logic              busy_q, last_q, wr_q;
  logic [ADDR_W-1:0] pa_q;
  logic [LEN_W-1:0]  rem_q, len_q, lim_q;
  logic [LEN_W-1:0]  lim_new, c_rem, c_lim, c_len;
  logic [ADDR_W-1:0] step_addr, c_addr;
  logic [LEN_W-1:0]  step_rem;
  logic              c_last, load, take;

  assign req_ready = !busy_q;
  assign pkt_valid = busy_q;
  assign pkt_addr  = pa_q;
  assign pkt_len   = len_q;
  assign pkt_last  = last_q;
  assign pkt_is_wr = wr_q;

  assign load = req_valid && !busy_q && (req_len != '0);
  assign take = busy_q && pkt_ready;

  split_limit #(.LEN_W(LEN_W), .WR_CAP(WR_CAP), .RD_CAP(RD_CAP)) u_lim (
    .dir    (split_pkg::dir_e'(req_is_wr)),
    .cfg_wr (cfg_wr_max),
    .cfg_rd (cfg_rd_max),
    .lim    (lim_new)
  );

  always_comb begin
    step_addr = pa_q + ADDR_W'(len_q);
    step_rem  = rem_q - len_q;
    c_addr    = load ? req_addr : step_addr;
    c_rem     = load ? req_len  : step_rem;
    c_lim     = load ? lim_new  : lim_q;
  end

  split_chunk #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .CL_BYTES(CL_BYTES)) u_chunk (
    .off_in (c_addr[PAGE_W-1:0]),
    .rem    (c_rem),
    .lim    (c_lim),
    .len    (c_len),
    .last   (c_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      wr_q   <= 1'b0;
      pa_q   <= '0;
      rem_q  <= '0;
      len_q  <= '0;
      lim_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      pa_q   <= req_addr;
      rem_q  <= req_len;
      lim_q  <= lim_new;
      wr_q   <= req_is_wr;
      len_q  <= c_len;
      last_q <= c_last;
    end else if (take) begin
      if (last_q) begin
        busy_q <= 1'b0;
      end else begin
        pa_q   <= step_addr;
        rem_q  <= step_rem;
        len_q  <= c_len;
        last_q <= c_last;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !pkt_valid && req_ready); // R1
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> !req_ready); // R2
  AST_ZERO_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == '0) |=> !pkt_valid); // R3
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> ((PAGE_W+2)'(pkt_addr[PAGE_W-1:0]) + (PAGE_W+2)'(pkt_len)
                   <= (PAGE_W+2)'(PAGE_BYTES))); // R4
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_len != '0) &&
      (pkt_len <= LEN_W'(pkt_is_wr ? WR_CAP : RD_CAP))); // R5
  AST_SPLIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_last) |->
      ((pkt_addr[CL_W-1:0] + pkt_len[CL_W-1:0]) == '0)); // R7
  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready && !pkt_last) |=>
      pkt_valid && (pkt_addr == $past(pkt_addr) + ADDR_W'($past(pkt_len)))); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_addr) &&
      $stable(pkt_len) && $stable(pkt_last) && $stable(pkt_is_wr)); // R9
  AST_FIRST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len != '0) |=>
      pkt_valid && (pkt_is_wr == $past(req_is_wr))); // R11
endmodule

// File: tb/sim_req_splitter.sv
module sim_req_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_is_wr = 1'b0, pkt_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0, cfg_wr_max = 13'd256, cfg_rd_max = 13'd512;
  logic req_ready, pkt_valid, pkt_last, pkt_is_wr;
  logic [AW-1:0] pkt_addr;
  logic [LW-1:0] pkt_len;

  int checks = 0, errors = 0;
  int exp_addr [0:255];
  int exp_len  [0:255];
  int exp_n;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_splitter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_is_wr(req_is_wr),
    .cfg_wr_max(cfg_wr_max), .cfg_rd_max(cfg_rd_max),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_addr(pkt_addr),
    .pkt_len(pkt_len), .pkt_last(pkt_last), .pkt_is_wr(pkt_is_wr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected packet sequence per R5..R8
  function automatic void plan(input longint addr, input int len, input bit wr,
                               input int mw, input int mr);
    longint cur = addr;
    int rem = len;
    int lim = wr ? ((mw < 256) ? mw : 256) : ((mr < 512) ? mr : 512);
    exp_n = 0;
    while (rem > 0) begin
      int room = 4096 - int'(cur % 4096);
      int take;
      if (rem <= lim && rem <= room) take = rem;
      else begin
        longint edge_al = ((cur + lim) / 64) * 64;
        take = int'(edge_al - cur);
        if (room < take) take = room;
      end
      exp_addr[exp_n] = int'(cur & 64'hFFFF_FFFF);
      exp_len[exp_n]  = take;
      exp_n++;
      cur = (cur + take) % 64'h1_0000_0000;
      rem -= take;
    end
  endfunction

  task automatic run_req(input longint addr, input int len, input bit wr,
                         input int mw, input int mr, input int stall_pct);
    int idx = 0;
    int lim = wr ? ((mw < 256) ? mw : 256) : ((mr < 512) ? mr : 512);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = AW'(addr); req_len = LW'(len); req_is_wr = wr;
    cfg_wr_max = LW'(mw); cfg_rd_max = LW'(mr);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_wr_max = LW'(128 << ($urandom % 6)); // later changes must not matter (R5)
    cfg_rd_max = LW'(128 << ($urandom % 6));
    if (len == 0) begin
      chk(pkt_valid === 1'b0, "R3", "no packet for zero length", pkt_valid, 0);
      chk(req_ready === 1'b1, "R3", "still ready", req_ready, 1);
      return;
    end
    plan(addr, len, wr, mw, mr);
    while (idx < exp_n) begin
      bit r;
      chk(pkt_valid === 1'b1, "R11", "packet valid", pkt_valid, 1);
      chk(req_ready === 1'b0, "R2", "busy not ready", req_ready, 0);
      chk(pkt_addr === AW'(exp_addr[idx]), "R8", "packet address", pkt_addr, exp_addr[idx]);
      chk(pkt_len === LW'(exp_len[idx]), "R7", "packet length", pkt_len, exp_len[idx]);
      chk(pkt_last === (idx == exp_n - 1), "R8", "last flag", pkt_last, idx == exp_n - 1);
      chk(pkt_is_wr === wr, "R10", "direction", pkt_is_wr, wr);
      chk((int'(pkt_addr % 4096) + int'(pkt_len)) <= 4096, "R4", "page end",
          int'(pkt_addr % 4096) + int'(pkt_len), 4096);
      chk(int'(pkt_len) <= lim, "R5", "length limit", pkt_len, lim);
      r = (int'($urandom % 100) >= stall_pct);
      pkt_ready = r;
      @(negedge clk);
      if (r) idx++;
    end
    pkt_ready = 1'b0;
    chk(pkt_valid === 1'b0, "R2", "idle after last", pkt_valid, 0);
    chk(req_ready === 1'b1, "R2", "ready after last", req_ready, 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pkt_valid === 1'b0, "R1", "valid after reset", pkt_valid, 0);
    chk(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
    // R6: unaligned single packet
    run_req(64'h1003, 100, 1'b1, 256, 512, 0);
    // R4: short write crossing a page
    run_req(64'h0FF0, 64, 1'b1, 4096, 4096, 30);
    // R7: read with small limit, unaligned start
    run_req(64'h20, 300, 1'b0, 4096, 128, 50);
    // R5: long read clipped by internal cap
    run_req(64'h0, 8191, 1'b0, 4096, 4096, 20);
    // R3: zero length
    run_req(64'h400, 0, 1'b1, 256, 512, 0);
    // R9: heavy stalls on a write
    run_req(64'h7FFF_FFC1, 700, 1'b1, 128, 512, 80);
    // address wrap at the top of the space
    run_req(64'hFFFF_FF00, 256, 1'b0, 512, 512, 10);
    for (int i = 0; i < 150; i++) begin
      longint a = longint'($urandom);
      int l = (($urandom % 4) == 0) ? int'($urandom % 130) : int'($urandom % 8192);
      run_req(a, l, 1'($urandom % 2), 128 << ($urandom % 6), 128 << ($urandom % 6),
              int'($urandom % 60));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule